// File: doc/BRIEF.md
# Decimal and ASCII Adjust Unit

This block is a purely combinational corrector for a 16-bit accumulator that is split into a high byte and a low byte. It takes a value that an earlier add, subtract or multiply has already left in the accumulator and applies one of six decimal corrections. Two of them work on packed BCD: the adjust after add and the adjust after subtract. Four work on unpacked, ASCII-style digits: the adjust after add, after subtract, after multiply, and the adjust before divide.

The caller supplies the operation code, the accumulator and the incoming carry and auxiliary-carry flags. The unit returns the corrected accumulator and five flag outputs. Alongside the flags it returns an update mask that tells the flag register which of them to write. Flags that an operation leaves undefined are driven to 0, and their mask bits are cleared. The unit has no clock and no state.

Top module: `dau_adjust_unit`

## Requirements
- R1: The operation code op_i selects the operation: 0 unpacked add adjust, 1 unpacked subtract adjust, 2 multiply split, 3 divide join, 4 packed add adjust, 5 packed subtract adjust. The bits of upd_o are 0 carry, 1 auxiliary carry, 2 sign, 3 zero and 4 parity. A flag output whose mask bit is 0 is driven to 0.
- R2: Op 0 applies a correction when the low nibble of the low byte exceeds 9 or af_i is 1. The correction adds 6 to the low byte and adds 1 to the high byte, and sets carry and auxiliary carry. Without a correction both flags are 0. In both cases the upper nibble of the low byte is then cleared. The mask is 5'b00011.
- R3: Op 1 uses the same test as op 0. The correction subtracts 6 from the low byte and 1 from the high byte, and sets carry and auxiliary carry. Without a correction both flags are 0. The upper nibble of the low byte is then cleared. The mask is 5'b00011.
- R4: Op 2 places the low byte divided by 10 in the high byte and the low byte modulo 10 in the low byte. The mask is 5'b11100.
- R5: Op 3 places (high × 10 + low) mod 256 in the low byte and clears the high byte. The mask is 5'b11100.
- R6: Op 4 adds 0x06 to the low byte when its low nibble exceeds 9 or af_i is 1, and then sets auxiliary carry. It adds 0x60 when the original low byte exceeds 0x99 or cf_i is 1, and then sets carry. The high byte is unchanged. The mask is 5'b11111.
- R7: Op 5 applies the same tests as op 4, but subtracts 0x06 and 0x60 instead of adding them. It sets auxiliary carry and carry in the same way. The high byte is unchanged. The mask is 5'b11111.
- R8: Op codes 6 and 7 pass the accumulator through unchanged, drive every flag to 0 and give a mask of 0.
- R9: For ops 2 and 3, cf_i and af_i have no effect on any output.
- R10: When the mask enables them: sign is bit 7 of the new low byte, zero is 1 when that byte is 0, and parity is 1 when that byte has an even number of ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code |
| acc_i | input | 16 | Accumulator before correction (high byte in 15:8) |
| cf_i | input | 1 | Incoming carry flag |
| af_i | input | 1 | Incoming auxiliary-carry flag |
| acc_o | output | 16 | Corrected accumulator |
| cf_o | output | 1 | Carry result |
| af_o | output | 1 | Auxiliary-carry result |
| sf_o | output | 1 | Sign result |
| zf_o | output | 1 | Zero result |
| pf_o | output | 1 | Even-parity result |
| upd_o | output | 5 | Flag update mask |

## Verification
In the packed operations the low-nibble correction and the high correction can both fire for the same input. Their interaction decides the result, because the high test looks at the original byte rather than the byte after the 0x06 step. The bench provokes this with inputs such as 0x9C and 0x9A: the 0x06 step carries into the upper nibble, and the second step then wraps the byte through zero. For packed subtract it uses 0x00 with both flags set. Each case is judged against hand-computed bytes and against carry and auxiliary carry both being 1.

// File: rtl/dau_pkg.sv
package dau_pkg;
  localparam int BYTE_W     = 8;
  localparam int NIB_W      = BYTE_W / 2;
  localparam int ACC_W      = 2 * BYTE_W;
  localparam int DIGIT_BASE = 10;
  localparam int FLAG_N     = 5;

  typedef enum logic [2:0] {
    OP_UADD = 3'd0,
    OP_USUB = 3'd1,
    OP_MSPL = 3'd2,
    OP_DJN  = 3'd3,
    OP_PADD = 3'd4,
    OP_PSUB = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } op_e;

  // bit order matches upd_o: 0 carry, 1 aux, 2 sign, 3 zero, 4 parity
  typedef struct packed {
    logic pf;
    logic zf;
    logic sf;
    logic af;
    logic cf;
  } flags_t;

  localparam flags_t MASK_UNPK = '{pf: 1'b0, zf: 1'b0, sf: 1'b0, af: 1'b1, cf: 1'b1};
  localparam flags_t MASK_DIG  = '{pf: 1'b1, zf: 1'b1, sf: 1'b1, af: 1'b0, cf: 1'b0};
  localparam flags_t MASK_PKD  = '{pf: 1'b1, zf: 1'b1, sf: 1'b1, af: 1'b1, cf: 1'b1};

  function automatic logic nib_over(input logic [NIB_W-1:0] n);
    return n > NIB_W'(DIGIT_BASE - 1);
  endfunction

  function automatic flags_t result_flags(input logic [BYTE_W-1:0] b);
    flags_t f;
    f.cf = 1'b0;
    f.af = 1'b0;
    f.sf = b[BYTE_W-1];
    f.zf = (b == '0);
    f.pf = ~(^b);
    return f;
  endfunction
endpackage

// File: rtl/dau_unpacked.sv
module dau_unpacked
  import dau_pkg::*;
(
  input  logic              sub_i,
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic              af_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              fix_o
);
  localparam logic [BYTE_W-1:0] STEP = BYTE_W'(16 - DIGIT_BASE);
  logic [BYTE_W-1:0] lo_adj;

  always_comb begin
    fix_o  = nib_over(lo_i[NIB_W-1:0]) | af_i;
    lo_adj = lo_i;
    hi_o   = hi_i;
    if (fix_o) begin
      lo_adj = sub_i ? (lo_i - STEP) : (lo_i + STEP);
      hi_o   = sub_i ? (hi_i - 1'b1) : (hi_i + 1'b1);
    end
    lo_o = {{NIB_W{1'b0}}, lo_adj[NIB_W-1:0]};
  end
endmodule

// File: rtl/dau_digit.sv
module dau_digit
  import dau_pkg::*;
(
  input  logic [BYTE_W-1:0] lo_i,
  input  logic [BYTE_W-1:0] hi_i,
  output logic [BYTE_W-1:0] tens_o,
  output logic [BYTE_W-1:0] units_o,
  output logic [BYTE_W-1:0] join_o
);
  localparam logic [BYTE_W-1:0] BASE_B = BYTE_W'(DIGIT_BASE);
  logic [ACC_W-1:0] prod;

  always_comb begin
    tens_o  = lo_i / BASE_B;
    units_o = lo_i % BASE_B;
    prod    = {{BYTE_W{1'b0}}, hi_i} * {{BYTE_W{1'b0}}, BASE_B};
    join_o  = prod[BYTE_W-1:0] + lo_i;
  end
endmodule

// File: rtl/dau_packed.sv
module dau_packed
  import dau_pkg::*;
(
  input  logic              sub_i,
  input  logic [BYTE_W-1:0] val_i,
  input  logic              cf_i,
  input  logic              af_i,
  output logic [BYTE_W-1:0] val_o,
  output logic              lo_fix_o,
  output logic              hi_fix_o
);
  localparam logic [BYTE_W-1:0] LO_STEP = BYTE_W'(16 - DIGIT_BASE);
  localparam logic [BYTE_W-1:0] HI_STEP = LO_STEP << NIB_W;
  localparam logic [BYTE_W-1:0] HI_LIM  = {NIB_W'(DIGIT_BASE - 1), NIB_W'(DIGIT_BASE - 1)};
  logic [BYTE_W-1:0] corr;

  always_comb begin
    lo_fix_o = nib_over(val_i[NIB_W-1:0]) | af_i;
    // high test uses the byte before any low correction
    hi_fix_o = (val_i > HI_LIM) | cf_i;
    corr     = (lo_fix_o ? LO_STEP : '0) + (hi_fix_o ? HI_STEP : '0);
    val_o    = sub_i ? (val_i - corr) : (val_i + corr);
  end
endmodule

// File: rtl/dau_adjust_unit.sv
module dau_adjust_unit
  import dau_pkg::*;
(
  input  logic [2:0]        op_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic              cf_i,
  input  logic              af_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              cf_o,
  output logic              af_o,
  output logic              sf_o,
  output logic              zf_o,
  output logic              pf_o,
  output logic [FLAG_N-1:0] upd_o
);
  logic [BYTE_W-1:0] lo_in, hi_in;
  assign lo_in = acc_i[BYTE_W-1:0];
  assign hi_in = acc_i[ACC_W-1:BYTE_W];

  // named events for the checker
  logic ascii_fix, dec_lo_fix, dec_hi_fix;

  logic [BYTE_W-1:0] u_lo, u_hi;
  logic              u_sub, p_sub;
  assign u_sub = (op_i == OP_USUB);
  assign p_sub = (op_i == OP_PSUB);

  dau_unpacked u_unpk (
    .sub_i(u_sub), .lo_i(lo_in), .hi_i(hi_in), .af_i(af_i),
    .lo_o(u_lo), .hi_o(u_hi), .fix_o(ascii_fix)
  );

  logic [BYTE_W-1:0] d_tens, d_units, d_join;
  dau_digit u_dig (
    .lo_i(lo_in), .hi_i(hi_in),
    .tens_o(d_tens), .units_o(d_units), .join_o(d_join)
  );

  logic [BYTE_W-1:0] p_val;
  dau_packed u_pkd (
    .sub_i(p_sub), .val_i(lo_in), .cf_i(cf_i), .af_i(af_i),
    .val_o(p_val), .lo_fix_o(dec_lo_fix), .hi_fix_o(dec_hi_fix)
  );

  flags_t flg, msk;

  always_comb begin
    acc_o = acc_i;
    flg   = '0;
    msk   = '0;
    unique case (op_e'(op_i))
      OP_UADD, OP_USUB: begin
        acc_o  = {u_hi, u_lo};
        flg.cf = ascii_fix;
        flg.af = ascii_fix;
        msk    = MASK_UNPK;
      end
      OP_MSPL: begin
        acc_o = {d_tens, d_units};
        flg   = result_flags(d_units);
        msk   = MASK_DIG;
      end
      OP_DJN: begin
        acc_o = {{BYTE_W{1'b0}}, d_join};
        flg   = result_flags(d_join);
        msk   = MASK_DIG;
      end
      OP_PADD, OP_PSUB: begin
        acc_o  = {hi_in, p_val};
        flg    = result_flags(p_val);
        flg.af = dec_lo_fix;
        flg.cf = dec_hi_fix;
        msk    = MASK_PKD;
      end
      default: begin
        acc_o = acc_i;
        flg   = '0;
        msk   = '0;
      end
    endcase
  end

  assign cf_o  = flg.cf & msk.cf;
  assign af_o  = flg.af & msk.af;
  assign sf_o  = flg.sf & msk.sf;
  assign zf_o  = flg.zf & msk.zf;
  assign pf_o  = flg.pf & msk.pf;
  assign upd_o = msk;
endmodule

// File: rtl/dau_adjust_chk.sv
module dau_adjust_chk
  import dau_pkg::*;
(
  input logic [2:0]        op_i,
  input logic [ACC_W-1:0]  acc_i,
  input logic [ACC_W-1:0]  acc_o,
  input logic              cf_o,
  input logic              af_o,
  input logic              sf_o,
  input logic              zf_o,
  input logic              pf_o,
  input logic [FLAG_N-1:0] upd_o,
  input logic              ascii_fix,
  input logic              dec_lo_fix,
  input logic              dec_hi_fix
);
  always_comb begin
    // R1: flags outside the mask stay low
    a_r1_masked_low: assert (({pf_o, zf_o, sf_o, af_o, cf_o} & ~upd_o) == '0);
    if (op_i == 3'd0 || op_i == 3'd1) begin
      a_r2_upper_nib_clear: assert (acc_o[BYTE_W-1:NIB_W] == '0);
      a_r3_flags_follow_fix: assert (cf_o == ascii_fix && af_o == ascii_fix);
    end
    if (op_i == 3'd2) begin
      a_r4_digits_in_range: assert (acc_o[BYTE_W-1:0] < BYTE_W'(DIGIT_BASE)
                                    && acc_o[ACC_W-1:BYTE_W] <= BYTE_W'(255 / DIGIT_BASE));
    end
    if (op_i == 3'd3) begin
      a_r5_high_cleared: assert (acc_o[ACC_W-1:BYTE_W] == '0);
    end
    if (op_i == 3'd4 || op_i == 3'd5) begin
      a_r6_carry_from_hi: assert (cf_o == dec_hi_fix && af_o == dec_lo_fix);
      a_r7_high_kept: assert (acc_o[ACC_W-1:BYTE_W] == acc_i[ACC_W-1:BYTE_W]);
    end
    if (op_i[2:1] == 2'b11) begin
      a_r8_passthrough: assert (acc_o == acc_i && upd_o == '0);
    end
    if (upd_o[3]) begin
      a_r10_zero_matches: assert (zf_o == (acc_o[BYTE_W-1:0] == '0));
    end
  end
endmodule

bind dau_adjust_unit dau_adjust_chk u_chk (
  .op_i(op_i), .acc_i(acc_i), .acc_o(acc_o),
  .cf_o(cf_o), .af_o(af_o), .sf_o(sf_o), .zf_o(zf_o), .pf_o(pf_o),
  .upd_o(upd_o), .ascii_fix(ascii_fix),
  .dec_lo_fix(dec_lo_fix), .dec_hi_fix(dec_hi_fix)
);

// File: tb/tb_dau_adjust_unit.sv
module tb_dau_adjust_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [2:0]  op_i;
  logic [15:0] acc_i;
  logic        cf_i, af_i;
  logic [15:0] acc_o;
  logic        cf_o, af_o, sf_o, zf_o, pf_o;
  logic [4:0]  upd_o;

  dau_adjust_unit dut (
    .op_i(op_i), .acc_i(acc_i), .cf_i(cf_i), .af_i(af_i),
    .acc_o(acc_o), .cf_o(cf_o), .af_o(af_o), .sf_o(sf_o),
    .zf_o(zf_o), .pf_o(pf_o), .upd_o(upd_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // {req(4), op(3), acc(16), cf, af, exp_acc(16), exp_flags{pf,zf,sf,af,cf}(5), exp_mask(5)}
  localparam int VN = 25;
  localparam logic [50:0] VEC [VN] = '{
    {4'd2,  3'd0, 16'h006B, 1'b0, 1'b0, 16'h0101, 5'b00011, 5'b00011}, // R2
    {4'd2,  3'd0, 16'h0067, 1'b0, 1'b0, 16'h0007, 5'b00000, 5'b00011}, // R2
    {4'd2,  3'd0, 16'h0003, 1'b0, 1'b1, 16'h0109, 5'b00011, 5'b00011}, // R2
    {4'd2,  3'd0, 16'h006A, 1'b0, 1'b0, 16'h0100, 5'b00011, 5'b00011}, // R2
    {4'd3,  3'd1, 16'h00FB, 1'b0, 1'b1, 16'hFF05, 5'b00011, 5'b00011}, // R3
    {4'd3,  3'd1, 16'h0502, 1'b0, 1'b0, 16'h0502, 5'b00000, 5'b00011}, // R3
    {4'd3,  3'd1, 16'h0301, 1'b0, 1'b1, 16'h020B, 5'b00011, 5'b00011}, // R3
    {4'd4,  3'd2, 16'h0024, 1'b0, 1'b0, 16'h0306, 5'b10000, 5'b11100}, // R4
    {4'd4,  3'd2, 16'h00FF, 1'b0, 1'b0, 16'h1905, 5'b10000, 5'b11100}, // R4
    {4'd9,  3'd2, 16'h0050, 1'b1, 1'b1, 16'h0800, 5'b11000, 5'b11100}, // R9
    {4'd5,  3'd3, 16'h0205, 1'b0, 1'b0, 16'h0019, 5'b00000, 5'b11100}, // R5
    {4'd9,  3'd3, 16'h0508, 1'b1, 1'b1, 16'h003A, 5'b10000, 5'b11100}, // R9
    {4'd10, 3'd3, 16'h0D00, 1'b0, 1'b0, 16'h0082, 5'b10100, 5'b11100}, // R10
    {4'd5,  3'd3, 16'h1A04, 1'b0, 1'b0, 16'h0008, 5'b00000, 5'b11100}, // R5
    {4'd6,  3'd4, 16'h007C, 1'b0, 1'b0, 16'h0082, 5'b10110, 5'b11111}, // R6
    {4'd6,  3'd4, 16'h009C, 1'b0, 1'b0, 16'h0002, 5'b00011, 5'b11111}, // R6
    {4'd6,  3'd4, 16'h1245, 1'b0, 1'b0, 16'h1245, 5'b00000, 5'b11111}, // R6
    {4'd6,  3'd4, 16'h0012, 1'b1, 1'b0, 16'h0072, 5'b10001, 5'b11111}, // R6
    {4'd6,  3'd4, 16'h009A, 1'b0, 1'b0, 16'h0000, 5'b11011, 5'b11111}, // R6
    {4'd7,  3'd5, 16'h002F, 1'b0, 1'b0, 16'h0029, 5'b00010, 5'b11111}, // R7
    {4'd7,  3'd5, 16'h00D7, 1'b1, 1'b0, 16'h0077, 5'b10001, 5'b11111}, // R7
    {4'd7,  3'd5, 16'h001D, 1'b0, 1'b0, 16'h0017, 5'b10010, 5'b11111}, // R7
    {4'd7,  3'd5, 16'h3400, 1'b1, 1'b1, 16'h349A, 5'b10111, 5'b11111}, // R7
    {4'd8,  3'd6, 16'hABCD, 1'b1, 1'b1, 16'hABCD, 5'b00000, 5'b00000}, // R8
    {4'd8,  3'd7, 16'h1234, 1'b1, 1'b0, 16'h1234, 5'b00000, 5'b00000}  // R8
  };

  task automatic check(input int req, input logic [15:0] ea,
                       input logic [4:0] ef, input logic [4:0] em);
    logic [4:0] af_vec;
    af_vec = {pf_o, zf_o, sf_o, af_o, cf_o};
    total++;
    if (acc_o !== ea || af_vec !== ef || upd_o !== em) begin
      bad++;
      $display("FAIL R%0d op=%0d acc_in=%h: got acc=%h flags=%b mask=%b, expected acc=%h flags=%b mask=%b",
               req, op_i, acc_i, acc_o, af_vec, upd_o, ea, ef, em);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [15:0] a,
                       input logic c, input logic x);
    @(posedge clk);
    op_i = op; acc_i = a; cf_i = c; af_i = x;
    @(negedge clk);
  endtask

  initial begin
    op_i = 3'd6; acc_i = 16'h0000; cf_i = 1'b0; af_i = 1'b0;
    repeat (3) @(posedge clk);
    // R8 reset-time state: reserved op with zero input gives all zeros
    @(negedge clk);
    check(8, 16'h0000, 5'b00000, 5'b00000);
    rst = 1'b0;

    for (int i = 0; i < VN; i++) begin
      apply(VEC[i][46:44], VEC[i][43:28], VEC[i][27], VEC[i][26]);
      check(int'(VEC[i][50:47]), VEC[i][25:10], VEC[i][9:5], VEC[i][4:0]);
    end

    // R9: flag inputs ignored by the split and join operations
    apply(3'd2, 16'h0063, 1'b0, 1'b0);
    check(9, 16'h0909, 5'b10000, 5'b11100);
    apply(3'd2, 16'h0063, 1'b1, 1'b1);
    check(9, 16'h0909, 5'b10000, 5'b11100);
    // R1: masked-off flags low even with both flag inputs set
    apply(3'd0, 16'h0011, 1'b1, 1'b1);
    check(1, 16'h0107, 5'b00011, 5'b00011);
    // R6 both corrections, carry in forces the high step
    apply(3'd4, 16'h0099, 1'b1, 1'b1);
    check(6, 16'h00FF, 5'b10111, 5'b11111);
    // R10 sign from split units digit never set; join with sign
    apply(3'd3, 16'h0C08, 1'b0, 1'b0);
    check(10, 16'h0080, 5'b00100, 5'b11100);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule